// File: doc/BRIEF.md
# Bus-Matching FIFO Read Port

This block sits between an external first-in first-out memory that stores 36-bit long words and a reader whose port may be 36, 18 or 9 bits wide. A two-bit size input selects the width. In the two narrow modes one long word is handed out as two halves or four bytes, most significant part first. Each part is right-justified in the output register and the unused upper bits are zero.

The external memory presents its oldest long word on `fifo_rdata` while `fifo_ne` is high. The port pops that word with `fifo_pop` when the first part of a long word is read, and keeps the word in a holding register until its last part has been read. The not-empty indication seen by the reader, `empty_n`, stays high while parts of the held word remain. It drops only on the edge that takes the final part of the last long word. A read happens on a rising clock edge when all of these hold:
- the chip select is low;
- the write/read select is low;
- the enable is high;
- `empty_n` is high;
- the size code is not the "no access" value.

Top module: `busmatch_rd_port`

## Requirements
- R1: A read occurs on a rising `clk` edge only when `cs_n`=0, `wr_rd`=0, `en`=1, `empty_n`=1 and `size`!=2'b11. Otherwise no part is taken and `fifo_pop` stays low.
- R2: With `size`=2'b11 the port never pops, and the output register keeps its value.
- R3: `dout_oe` is 1 exactly when `cs_n`=0 and `wr_rd`=0. While `dout_oe` is 0, `dout` reads all zeros; otherwise it shows the output register.
- R4: In long mode (`size`=2'b00) every read pops one long word and presents all 36 bits.
- R5: In half mode (`size`=2'b01) the first read pops and presents bits 35:18 in `dout[17:0]`. The second read presents bits 17:0. The upper 18 bits of `dout` are zero.
- R6: In byte mode (`size`=2'b10) four reads present bits 35:27, 26:18, 17:9 and 8:0, in that order, in `dout[8:0]`. The upper bits are zero, and only the first read pops.
- R7: `empty_n` stays 1 while parts of the held long word remain. It becomes 0 right after the edge that reads the last part of a long word, if `fifo_ne` is then 0.
- R8: A change of `size` from one cycle to the next discards the rest of the held long word. The next read starts a new long word with a pop.
- R9: After reset the part counter is zero, the output register is zero, and `empty_n` equals `fifo_ne`.
- R10: A read attempt while `empty_n`=0 has no effect on `dout` and does not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_rd | input | 1 | Direction select, 0 for read |
| en | input | 1 | Read enable |
| size | input | 2 | 00 long, 01 half, 10 byte, 11 no access |
| fifo_rdata | input | 36 | Oldest long word of the external memory |
| fifo_ne | input | 1 | External memory holds at least one word |
| fifo_pop | output | 1 | Removes the oldest long word at this edge |
| dout | output | 36 | Read data, zero when not driven |
| dout_oe | output | 1 | Output drive enable |
| empty_n | output | 1 | Reader-visible not-empty |

## Verification
On every cycle, the assertions check the following:
- pops occur only at the start of a long word, and never while the port is empty or in the no-access code;
- the output gate follows the select pins;
- the visible not-empty stays high while parts remain;
- the part index restarts after a size change.

Only the bench scenarios can show which bits each part carries and in what order. The same holds for the exact edge on which `empty_n` drops, for whether the discarded remainder after a size change is really lost, and for the return to the reset state when reset hits in the middle of a word.

// File: rtl/brp_pkg.sv
package brp_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_OFF  = 2'b11
  } size_e;

  // index of the final part of a long word for each size code
  function automatic logic [1:0] final_part(input size_e s);
    case (s)
      SZ_HALF: final_part = 2'd1;
      SZ_BYTE: final_part = 2'd3;
      default: final_part = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/brp_qualify.sv
module brp_qualify
  import brp_pkg::*;
(
  input  logic  cs_n,
  input  logic  wr_rd,
  input  logic  en,
  input  size_e size,
  input  logic  vis_ne,
  output logic  oe,
  output logic  rd_fire
);

  assign oe      = !cs_n && !wr_rd;
  assign rd_fire = oe && en && vis_ne && (size != SZ_OFF);

endmodule

// File: rtl/brp_seq.sv
module brp_seq
  import brp_pkg::*;
#(
  parameter int LONG_W = 36,
  localparam int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  size_e             size,
  input  logic              rd_fire,
  input  logic [LONG_W-1:0] fifo_rdata,
  input  logic              fifo_ne,
  output logic [IDX_W-1:0]  sub_idx,
  output logic [LONG_W-1:0] src_word,
  output logic              fifo_pop,
  output logic              vis_ne
);

  size_e             size_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LONG_W-1:0] hold_q;
  logic              size_chg;
  logic              start;
  logic              at_last;

  assign size_chg = (size != size_q);
  assign sub_idx  = size_chg ? '0 : idx_q;
  assign vis_ne   = fifo_ne || (sub_idx != '0);
  assign start    = rd_fire && (sub_idx == '0);
  assign at_last  = (sub_idx == final_part(size));
  assign fifo_pop = start;
  assign src_word = start ? fifo_rdata : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_LONG;
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      size_q <= size;
      if (start) hold_q <= fifo_rdata;
      if (rd_fire) idx_q <= at_last ? '0 : sub_idx + 1'b1;
      else         idx_q <= sub_idx;
    end
  end

endmodule

// File: rtl/brp_slice.sv
module brp_slice
  import brp_pkg::*;
#(
  parameter int LONG_W = 36,
  localparam int HALF_W = LONG_W / 2,
  localparam int BYTE_W = LONG_W / 4,
  localparam int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  size_e             size,
  input  logic [1:0]        sub_idx,
  input  logic              rd_fire,
  input  logic [LONG_W-1:0] src_word,
  output logic [LONG_W-1:0] dout_q
);

  logic [BYTE_W-1:0] lane [LANES];
  logic [LONG_W-1:0] part;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = src_word[LONG_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    part = '0;
    case (size)
      SZ_LONG: part = src_word;
      SZ_HALF: part[HALF_W-1:0] = sub_idx[0] ? src_word[HALF_W-1:0]
                                             : src_word[LONG_W-1 -: HALF_W];
      SZ_BYTE: part[BYTE_W-1:0] = lane[sub_idx];
      default: part = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (rd_fire) dout_q <= part;
  end

endmodule

// File: rtl/busmatch_rd_port.sv
module busmatch_rd_port
  import brp_pkg::*;
#(
  parameter int LONG_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_rd,
  input  logic              en,
  input  logic [1:0]        size,
  input  logic [LONG_W-1:0] fifo_rdata,
  input  logic              fifo_ne,
  output logic              fifo_pop,
  output logic [LONG_W-1:0] dout,
  output logic              dout_oe,
  output logic              empty_n
);

  size_e             size_s;
  logic              rd_fire;
  logic              vis_ne;
  logic [1:0]        sub_idx;
  logic [LONG_W-1:0] src_word;
  logic [LONG_W-1:0] dout_q;

  assign size_s  = size_e'(size);
  assign empty_n = vis_ne;
  assign dout    = dout_oe ? dout_q : '0;

  brp_qualify u_qual (
    .cs_n    (cs_n),
    .wr_rd   (wr_rd),
    .en      (en),
    .size    (size_s),
    .vis_ne  (vis_ne),
    .oe      (dout_oe),
    .rd_fire (rd_fire)
  );

  brp_seq #(.LONG_W(LONG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .size       (size_s),
    .rd_fire    (rd_fire),
    .fifo_rdata (fifo_rdata),
    .fifo_ne    (fifo_ne),
    .sub_idx    (sub_idx),
    .src_word   (src_word),
    .fifo_pop   (fifo_pop),
    .vis_ne     (vis_ne)
  );

  brp_slice #(.LONG_W(LONG_W)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .size     (size_s),
    .sub_idx  (sub_idx),
    .rd_fire  (rd_fire),
    .src_word (src_word),
    .dout_q   (dout_q)
  );

endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int LONG_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_rd,
  input logic              en,
  input logic [1:0]        size,
  input logic              fifo_pop,
  input logic [LONG_W-1:0] dout,
  input logic              dout_oe,
  input logic              empty_n,
  input logic              rd_fire,
  input logic [1:0]        sub_idx,
  input logic [LONG_W-1:0] dout_q
);

  a_r1_no_read_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rd_fire);

  a_r2_off_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b11) |-> !fifo_pop);

  a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b11) |=> $stable(dout_q));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || wr_rd) |-> (!dout_oe && dout == '0));

  a_r4_pop_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (sub_idx == 2'd0 && rd_fire));

  a_r5_half_range: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b01) |-> (sub_idx <= 2'd1));

  a_r7_hold_ne: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_idx != 2'd0) |-> empty_n);

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (size != $past(size)) |-> (sub_idx == 2'd0));

  a_r10_empty_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !fifo_pop);

endmodule

bind busmatch_rd_port brp_checker #(.LONG_W(LONG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .wr_rd    (wr_rd),
  .en       (en),
  .size     (size),
  .fifo_pop (fifo_pop),
  .dout     (dout),
  .dout_oe  (dout_oe),
  .empty_n  (empty_n),
  .rd_fire  (rd_fire),
  .sub_idx  (sub_idx),
  .dout_q   (dout_q)
);

// File: tb/busmatch_rd_port_tb.sv
module busmatch_rd_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        wr_rd = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [35:0] fifo_rdata;
  logic        fifo_ne;
  logic        fifo_pop;
  logic [35:0] dout;
  logic        dout_oe;
  logic        empty_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [35:0] mem [8];
  int wp = 0;
  int rp = 0;

  always #2 clk = ~clk;

  assign fifo_ne    = (wp != rp);
  assign fifo_rdata = mem[rp % 8];

  always @(posedge clk) if (fifo_pop) rp <= rp + 1;

  busmatch_rd_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en),
    .size(size), .fifo_rdata(fifo_rdata), .fifo_ne(fifo_ne),
    .fifo_pop(fifo_pop), .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  parts;
    logic [35:0] word;
    logic [35:0] e0;
    logic [35:0] e1;
    logic [35:0] e2;
    logic [35:0] e3;
  } vec_t;

  localparam vec_t TBL [4] = '{
    '{2'b00, 3'd1, {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4},
      {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4}, 36'h0, 36'h0, 36'h0},
    '{2'b01, 3'd2, {9'h155, 9'h0AA, 9'h133, 9'h0CC},
      {18'h0, 9'h155, 9'h0AA}, {18'h0, 9'h133, 9'h0CC}, 36'h0, 36'h0},
    '{2'b10, 3'd4, {9'h101, 9'h002, 9'h103, 9'h004},
      {27'h0, 9'h101}, {27'h0, 9'h002}, {27'h0, 9'h103}, {27'h0, 9'h004}},
    '{2'b10, 3'd4, {9'h1A1, 9'h0B2, 9'h1C3, 9'h0D4},
      {27'h0, 9'h1A1}, {27'h0, 9'h0B2}, {27'h0, 9'h1C3}, {27'h0, 9'h0D4}}
  };

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [35:0] w);
    mem[wp % 8] = w;
    wp++;
  endtask

  task automatic reading(input logic [1:0] s, input logic e);
    cs_n = 1'b0; wr_rd = 1'b0; size = s; en = e;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %h expected %h", 36'h0, 36'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] last;
    int rp0;
    step(); step(); step();
    rst_n = 1'b1;
    #1;
    // R9 reset state
    check(empty_n == 1'b0, "R9 empty_n", 36'(empty_n), 36'h0);
    check(dout == '0 && dout_oe == 1'b0, "R3 idle gate", dout, 36'h0);
    cs_n = 1'b0; wr_rd = 1'b0; #1;
    check(dout_oe == 1'b1 && dout == '0, "R9 out reg zero", dout, 36'h0);

    // table walk: R4 R5 R6 R7
    for (int v = 0; v < 4; v++) begin
      push(TBL[v].word);
      reading(TBL[v].mode, 1'b1);
      #1;
      check(empty_n == 1'b1, "R7 ne before read", 36'(empty_n), 36'h1);
      for (int k = 0; k < int'(TBL[v].parts); k++) begin
        logic [35:0] ex;
        ex = (k == 0) ? TBL[v].e0 : (k == 1) ? TBL[v].e1 :
             (k == 2) ? TBL[v].e2 : TBL[v].e3;
        step();
        check(dout == ex, "R4/R5/R6 part data", dout, ex);
        check(rp == wp, "R4 single pop per long word", 36'(rp), 36'(wp));
        check(empty_n == (k != int'(TBL[v].parts) - 1), "R7 empty edge",
              36'(empty_n), 36'(k != int'(TBL[v].parts) - 1));
      end
    end

    // R10 read attempt while empty
    last = dout;
    rp0 = rp;
    step(); step();
    check(dout == last, "R10 dout unchanged", dout, last);
    check(rp == rp0, "R10 no pop", 36'(rp), 36'(rp0));

    // R2 no-access size code
    push({9'h011, 9'h022, 9'h033, 9'h044});
    reading(2'b11, 1'b1);
    step(); step();
    check(dout == last, "R2 dout unchanged", dout, last);
    check(rp == rp0, "R2 no pop", 36'(rp), 36'(rp0));
    size = 2'b00;
    step();
    check(dout == {9'h011, 9'h022, 9'h033, 9'h044}, "R4 after off", dout,
          {9'h011, 9'h022, 9'h033, 9'h044});

    // R3 / R1 gating conditions
    push(36'h123456789);
    rp0 = rp;
    cs_n = 1'b1; step();
    check(dout == '0 && !dout_oe, "R3 cs high", dout, 36'h0);
    check(rp == rp0, "R1 cs high no read", 36'(rp), 36'(rp0));
    cs_n = 1'b0; wr_rd = 1'b1; step();
    check(dout == '0 && !dout_oe, "R3 wr_rd high", dout, 36'h0);
    check(rp == rp0, "R1 wr_rd high no read", 36'(rp), 36'(rp0));
    wr_rd = 1'b0; en = 1'b0; step();
    check(rp == rp0, "R1 en low no read", 36'(rp), 36'(rp0));
    check(dout == {9'h011, 9'h022, 9'h033, 9'h044}, "R3 shows register", dout,
          {9'h011, 9'h022, 9'h033, 9'h044});
    en = 1'b1; step();
    check(dout == 36'h123456789, "R1 read fires", dout, 36'h123456789);

    // R8 size change discards remainder
    push({9'h1F1, 9'h0E2, 9'h1D3, 9'h0C4});
    push({9'h0A5, 9'h15A, 9'h0C3, 9'h13C});
    reading(2'b10, 1'b1);
    step();
    check(dout == {27'h0, 9'h1F1}, "R6 byte 0", dout, {27'h0, 9'h1F1});
    step();
    check(dout == {27'h0, 9'h0E2}, "R6 byte 1", dout, {27'h0, 9'h0E2});
    en = 1'b0; size = 2'b01; step();
    check(empty_n == 1'b1, "R8 ne from next word", 36'(empty_n), 36'h1);
    en = 1'b1; step();
    check(dout == {18'h0, 9'h0A5, 9'h15A}, "R8 restart upper half", dout,
          {18'h0, 9'h0A5, 9'h15A});
    step();
    check(dout == {18'h0, 9'h0C3, 9'h13C}, "R5 lower half", dout,
          {18'h0, 9'h0C3, 9'h13C});
    check(empty_n == 1'b0 && rp == wp, "R7 empty after last half",
          36'(empty_n), 36'h0);

    // R7 back-to-back words keep ne high
    push(36'hAAAA_5555_1);
    push(36'h5555_AAAA_2);
    step();
    check(empty_n == 1'b1, "R7 ne across words", 36'(empty_n), 36'h1);
    step(); step();
    check(empty_n == 1'b1, "R7 ne second word", 36'(empty_n), 36'h1);
    step();
    check(empty_n == 1'b0, "R7 empty after final", 36'(empty_n), 36'h0);

    // R9 reset in the middle of a word
    push(36'hF0F0F0F0F);
    size = 2'b10; step();
    check(empty_n == 1'b1, "R7 mid-word ne", 36'(empty_n), 36'h1);
    en = 1'b0;
    rst_n = 1'b0; #1;
    check(empty_n == 1'b0 && dout == '0, "R9 mid-word reset", dout, 36'h0);
    step(); rst_n = 1'b1; #1;
    check(empty_n == 1'b0, "R9 ne follows fifo", 36'(empty_n), 36'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule